// File: doc/BRIEF.md
# Time-of-Day Clock Controller with Set and Alarm Modes

This block keeps the time of day as six packed BCD digits (HH:MM:SS, 00:00:00 to 23:59:59). A synchronous one-pulse-per-second enable advances the count. A three-bit switch code selects one of three modes: run, set-time or set-alarm. The same two increment keys step the hour or the minute of whichever register the mode selects. A hold switch pauses and resumes the count, and an active-low clear input zeroes the time.

All logic runs on a single system clock. Key and hold inputs are sampled on that clock, and each acts on its falling edge, which for the keys is the release. The block also drives two status flags. One marks the first six seconds of every hour while in run mode. The other marks a match between the running time and the alarm hour and minute.

Top module: `tod_clock_top`

## Requirements
- R1: `disp_o` packs six 4-bit BCD digits. From bit 0 upward they are seconds units, seconds tens, minutes units, minutes tens, hours units and hours tens. After reset the display reads 00:00:00 and the mode is run.
- R2: In run mode, while running, each cycle with `tick_i` high adds one second. Seconds and minutes wrap from 59 to 00 with a carry into the next field. 23:59:59 wraps to 00:00:00.
- R3: `mode_sw_i` = 3'b110 selects run, 3'b101 selects set-time and 3'b011 selects set-alarm. The new mode shows on `mode_o` (0 run, 1 set-time, 2 set-alarm) one cycle later. Any other code leaves the mode unchanged.
- R4: Releasing `hr_key_i` (a 1-to-0 transition) adds one to the hours of the selected register, with a BCD carry from units to tens. Hours wrap from 23 to 00.
- R5: Releasing `min_key_i` adds one to the minutes of the selected register, with a BCD carry. Minutes wrap from 59 to 00 with no carry into the hours.
- R6: In set-time mode, `disp_o` shows the set-time register and the time register loads from it on every cycle. On return to run, counting resumes from the loaded value.
- R7: In set-alarm mode, `disp_o` shows the alarm register (seconds digits 0) and the time register does not change.
- R8: A 1-to-0 transition of `hold_sw_i` toggles the running state (`running_o`, 1 after reset). The time does not advance while running is low.
- R9: `clear_ni` low sets the time register to 00:00:00 on the next edge. This takes priority over ticks and over loading from the set-time register.
- R10: `chime_o` is high exactly when the mode is run and the time's minutes and seconds lie in 00:00 to 00:05.
- R11: `alarm_hit_o` is high exactly when the mode is run and the hours and minutes of the time equal those of the alarm register.
- R12: Each press-and-release gives exactly one increment, however long the key is held. In run mode the increment keys change neither the set-time nor the alarm register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-second advance enable, one cycle wide |
| mode_sw_i | input | 3 | Mode switch code |
| hold_sw_i | input | 1 | Hold switch; falling edge toggles running |
| clear_ni | input | 1 | Active-low time clear |
| hr_key_i | input | 1 | Hour increment key, active high |
| min_key_i | input | 1 | Minute increment key, active high |
| disp_o | output | 24 | Packed BCD of the register shown in the current mode |
| mode_o | output | 2 | Current mode: 0 run, 1 set-time, 2 set-alarm |
| running_o | output | 1 | High while the count is not held |
| chime_o | output | 1 | Hourly chime window flag |
| alarm_hit_o | output | 1 | Alarm hour and minute match flag |

## Verification
The bench drives the time across 23:59:59 and the edited fields across their top values. A design with a binary wrap or a stray carry would show 24:00:00, 0x5A in a field, or an hour bump on a minute wrap. Increment keys are held for several cycles to expose a design that steps on level rather than on release. Keys are also pressed in run mode, where a design that edits the wrong register would alter the set or alarm value seen later. Other checks cover an unlisted mode code, clear arriving together with a tick, and a stay in alarm mode. A design that drops the previous mode, lets the tick win over clear, or keeps counting in alarm mode shows a different display value on return to run.

// File: rtl/tod_pkg.sv
package tod_pkg;

    localparam int DIG_W   = 4;
    localparam int NUM_DIG = 6;
    localparam int TOD_W   = DIG_W * NUM_DIG;
    localparam int FIELD_W = 2 * DIG_W;

    typedef enum logic [1:0] {
        TOD_RUN = 2'd0,
        TOD_SET = 2'd1,
        TOD_ALM = 2'd2
    } tod_mode_e;

    typedef struct packed {
        logic [TOD_W-1:0] tod;
        logic [TOD_W-1:0] set_reg;
        logic [TOD_W-1:0] alm_reg;
        tod_mode_e        mode;
        logic             halted;
    } tod_state_t;

    // Two-digit BCD increment; returns {wrapped, next}. Wraps to 00 at {tens_max, units_max}.
    function automatic logic [FIELD_W:0] bcd_field_inc(
        input logic [FIELD_W-1:0] v,
        input logic [DIG_W-1:0]   tens_max,
        input logic [DIG_W-1:0]   units_max
    );
        logic [FIELD_W:0] r;
        if (v == {tens_max, units_max}) begin
            r = '0;
            r[FIELD_W] = 1'b1;
        end else if (v[DIG_W-1:0] == DIG_W'(9)) begin
            r = {1'b0, v[FIELD_W-1:DIG_W] + DIG_W'(1), {DIG_W{1'b0}}};
        end else begin
            r = {1'b0, v[FIELD_W-1:DIG_W], v[DIG_W-1:0] + DIG_W'(1)};
        end
        return r;
    endfunction

endpackage

// File: rtl/tod_fall_det.sv
module tod_fall_det #(
    parameter int W = 3
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = din_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) prev_q <= '0;
        else         prev_q <= prev_d;
    end

    assign fall_o = prev_q & ~din_i;
endmodule

// File: rtl/tod_second_step.sv
module tod_second_step
    import tod_pkg::*;
(
    input  logic [TOD_W-1:0] tod_i,
    output logic [TOD_W-1:0] tod_o
);
    logic [FIELD_W:0] sec_n, min_n, hr_n;

    always_comb begin
        sec_n = bcd_field_inc(tod_i[FIELD_W-1:0], DIG_W'(5), DIG_W'(9));
        min_n = bcd_field_inc(tod_i[2*FIELD_W-1:FIELD_W], DIG_W'(5), DIG_W'(9));
        hr_n  = bcd_field_inc(tod_i[3*FIELD_W-1:2*FIELD_W], DIG_W'(2), DIG_W'(3));
        tod_o = tod_i;
        tod_o[FIELD_W-1:0] = sec_n[FIELD_W-1:0];
        if (sec_n[FIELD_W]) begin
            tod_o[2*FIELD_W-1:FIELD_W] = min_n[FIELD_W-1:0];
            if (min_n[FIELD_W]) begin
                tod_o[3*FIELD_W-1:2*FIELD_W] = hr_n[FIELD_W-1:0];
            end
        end
    end
endmodule

// File: rtl/tod_edit_unit.sv
module tod_edit_unit
    import tod_pkg::*;
(
    input  logic [TOD_W-1:0] reg_i,
    input  logic             hr_inc_i,
    input  logic             min_inc_i,
    output logic [TOD_W-1:0] reg_o
);
    logic [FIELD_W:0] min_n, hr_n;

    always_comb begin
        min_n = bcd_field_inc(reg_i[2*FIELD_W-1:FIELD_W], DIG_W'(5), DIG_W'(9));
        hr_n  = bcd_field_inc(reg_i[3*FIELD_W-1:2*FIELD_W], DIG_W'(2), DIG_W'(3));
        reg_o = reg_i;
        if (min_inc_i) reg_o[2*FIELD_W-1:FIELD_W]   = min_n[FIELD_W-1:0];
        if (hr_inc_i)  reg_o[3*FIELD_W-1:2*FIELD_W] = hr_n[FIELD_W-1:0];
    end
endmodule

// File: rtl/tod_clock_top.sv
module tod_clock_top
    import tod_pkg::*;
#(
    parameter logic [2:0] RUN_CODE = 3'b110,
    parameter logic [2:0] SET_CODE = 3'b101,
    parameter logic [2:0] ALM_CODE = 3'b011
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic [2:0]       mode_sw_i,
    input  logic             hold_sw_i,
    input  logic             clear_ni,
    input  logic             hr_key_i,
    input  logic             min_key_i,
    output logic [TOD_W-1:0] disp_o,
    output logic [1:0]       mode_o,
    output logic             running_o,
    output logic             chime_o,
    output logic             alarm_hit_o
);
    localparam int NUM_EDIT  = 2;
    localparam int EDGE_W    = 3;
    localparam int EDGE_HOLD = 2;
    localparam int EDGE_HR   = 1;
    localparam int EDGE_MIN  = 0;

    tod_state_t st_d, st_q;

    logic [EDGE_W-1:0] fall;
    logic [TOD_W-1:0]  tod_stepped;
    logic [TOD_W-1:0]  edit_in  [NUM_EDIT];
    logic [TOD_W-1:0]  edit_out [NUM_EDIT];
    tod_mode_e         edit_mode[NUM_EDIT];

    tod_fall_det #(.W(EDGE_W)) u_fall (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .din_i  ({hold_sw_i, hr_key_i, min_key_i}),
        .fall_o (fall)
    );

    tod_second_step u_step (
        .tod_i (st_q.tod),
        .tod_o (tod_stepped)
    );

    assign edit_in[0]   = st_q.set_reg;
    assign edit_in[1]   = st_q.alm_reg;
    assign edit_mode[0] = TOD_SET;
    assign edit_mode[1] = TOD_ALM;

    for (genvar g = 0; g < NUM_EDIT; g++) begin : g_edit
        tod_edit_unit u_edit (
            .reg_i     (edit_in[g]),
            .hr_inc_i  (fall[EDGE_HR]  && (st_q.mode == edit_mode[g])),
            .min_inc_i (fall[EDGE_MIN] && (st_q.mode == edit_mode[g])),
            .reg_o     (edit_out[g])
        );
    end

    always_comb begin
        st_d = st_q;
        unique case (mode_sw_i)
            RUN_CODE: st_d.mode = TOD_RUN;
            SET_CODE: st_d.mode = TOD_SET;
            ALM_CODE: st_d.mode = TOD_ALM;
            default:  st_d.mode = st_q.mode;
        endcase
        st_d.set_reg = edit_out[0];
        st_d.alm_reg = edit_out[1];
        if (fall[EDGE_HOLD]) st_d.halted = ~st_q.halted;
        if (!clear_ni) begin
            st_d.tod = '0;
        end else if (st_q.mode == TOD_SET) begin
            st_d.tod = st_q.set_reg;
        end else if ((st_q.mode == TOD_RUN) && !st_q.halted && tick_i) begin
            st_d.tod = tod_stepped;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.tod     <= '0;
            st_q.set_reg <= '0;
            st_q.alm_reg <= '0;
            st_q.mode    <= TOD_RUN;
            st_q.halted  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    logic [TOD_W-1:0] tod_now;
    logic [1:0]       mode_now;
    logic             halt_now;
    assign tod_now  = st_q.tod;
    assign mode_now = st_q.mode;
    assign halt_now = st_q.halted;

    always_comb begin
        unique case (st_q.mode)
            TOD_SET: disp_o = st_q.set_reg;
            TOD_ALM: disp_o = st_q.alm_reg;
            default: disp_o = st_q.tod;
        endcase
    end

    assign mode_o      = st_q.mode;
    assign running_o   = ~st_q.halted;
    assign chime_o     = (st_q.mode == TOD_RUN) && (st_q.tod[2*FIELD_W-1:0] <= 16'h0005);
    assign alarm_hit_o = (st_q.mode == TOD_RUN) &&
                         (st_q.tod[TOD_W-1:FIELD_W] == st_q.alm_reg[TOD_W-1:FIELD_W]);
endmodule

// File: rtl/tod_clock_chk.sv
module tod_clock_chk #(
    parameter logic [2:0] RUN_CODE = 3'b110,
    parameter logic [2:0] SET_CODE = 3'b101,
    parameter logic [2:0] ALM_CODE = 3'b011
) (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        tick_i,
    input logic        clear_ni,
    input logic [2:0]  mode_sw_i,
    input logic [23:0] tod_now,
    input logic [1:0]  mode_now,
    input logic        halt_now,
    input logic        chime_o
);
    assert_bcd_digits_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tod_now[3:0] <= 4'd9) && (tod_now[7:4] <= 4'd5) && (tod_now[11:8] <= 4'd9) &&
        (tod_now[15:12] <= 4'd5) && (tod_now[19:16] <= 4'd9) && (tod_now[23:16] <= 8'h23));

    assert_tick_advances_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_now == 2'd0 && !halt_now && tick_i && clear_ni) |=> (tod_now != $past(tod_now)));

    assert_mode_kept_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_sw_i != RUN_CODE && mode_sw_i != SET_CODE && mode_sw_i != ALM_CODE)
        |=> $stable(mode_now));

    assert_alarm_freeze_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_now == 2'd2 && clear_ni) |=> $stable(tod_now));

    assert_hold_freeze_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_now == 2'd0 && halt_now && clear_ni) |=> $stable(tod_now));

    assert_clear_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clear_ni) |=> (tod_now == 24'h0));

    assert_chime_run_only_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        chime_o |-> (mode_now == 2'd0));
endmodule

bind tod_clock_top tod_clock_chk #(
    .RUN_CODE(RUN_CODE), .SET_CODE(SET_CODE), .ALM_CODE(ALM_CODE)
) chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .clear_ni  (clear_ni),
    .mode_sw_i (mode_sw_i),
    .tod_now   (tod_now),
    .mode_now  (mode_now),
    .halt_now  (halt_now),
    .chime_o   (chime_o)
);

// File: tb/tod_clock_top_tb_top.sv
module tod_clock_top_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, hold_sw = 1'b0, clear_n = 1'b1, hr_key = 1'b0, min_key = 1'b0;
    logic [2:0] mode_sw = 3'b110;
    logic [23:0] disp;
    logic [1:0]  mode;
    logic running, chime, alarm_hit;

    int checks = 0, errors = 0;
    bit cmp_en = 0;

    always #4 clk = ~clk;

    tod_clock_top dut_i (
        .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .mode_sw_i(mode_sw),
        .hold_sw_i(hold_sw), .clear_ni(clear_n), .hr_key_i(hr_key), .min_key_i(min_key),
        .disp_o(disp), .mode_o(mode), .running_o(running), .chime_o(chime),
        .alarm_hit_o(alarm_hit)
    );

    // behavioural reference
    int t_h, t_m, t_s, s_h, s_m, a_h, a_m, md;
    bit halted, p_hold, p_hr, p_mn;

    function automatic logic [23:0] pk(int h, int m, int s);
        return {4'(h / 10), 4'(h % 10), 4'(m / 10), 4'(m % 10), 4'(s / 10), 4'(s % 10)};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            t_h = 0; t_m = 0; t_s = 0; s_h = 0; s_m = 0; a_h = 0; a_m = 0;
            md = 0; halted = 0; p_hold = 0; p_hr = 0; p_mn = 0;
        end else begin
            bit hr_e, mn_e, hd_e;
            int nmd;
            hr_e = p_hr && !hr_key;
            mn_e = p_mn && !min_key;
            hd_e = p_hold && !hold_sw;
            nmd = md;
            if (mode_sw == 3'b110) nmd = 0;
            else if (mode_sw == 3'b101) nmd = 1;
            else if (mode_sw == 3'b011) nmd = 2;
            if (!clear_n) begin
                t_h = 0; t_m = 0; t_s = 0;
            end else if (md == 1) begin
                t_h = s_h; t_m = s_m; t_s = 0;
            end else if (md == 0 && !halted && tick) begin
                t_s++;
                if (t_s == 60) begin t_s = 0; t_m++; end
                if (t_m == 60) begin t_m = 0; t_h++; end
                if (t_h == 24) t_h = 0;
            end
            if (md == 1) begin
                if (hr_e) s_h = (s_h + 1) % 24;
                if (mn_e) s_m = (s_m + 1) % 60;
            end else if (md == 2) begin
                if (hr_e) a_h = (a_h + 1) % 24;
                if (mn_e) a_m = (a_m + 1) % 60;
            end
            if (hd_e) halted = !halted;
            md = nmd;
            p_hold = hold_sw; p_hr = hr_key; p_mn = min_key;
        end
    end

    task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            logic [23:0] ed;
            string dtag;
            if (md == 1) begin ed = pk(s_h, s_m, 0); dtag = "R6 disp"; end
            else if (md == 2) begin ed = pk(a_h, a_m, 0); dtag = "R7 disp"; end
            else begin ed = pk(t_h, t_m, t_s); dtag = "R2 disp"; end
            cmp(dtag, 32'(disp), 32'(ed));
            cmp("R3 mode", 32'(mode), 32'(md));
            cmp("R8 running", 32'(running), 32'(!halted));
            cmp("R10 chime", 32'(chime), 32'(md == 0 && t_m == 0 && t_s <= 5));
            cmp("R11 alarm_hit", 32'(alarm_hit), 32'(md == 0 && t_h == a_h && t_m == a_m));
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic ticks(int n);
        tick = 1'b1; cyc(n); tick = 1'b0;
    endtask
    task automatic press_hr(int n, int held);
        repeat (n) begin hr_key = 1'b1; cyc(held); hr_key = 1'b0; cyc(1); end
    endtask
    task automatic press_mn(int n, int held);
        repeat (n) begin min_key = 1'b1; cyc(held); min_key = 1'b0; cyc(1); end
    endtask
    task automatic flip_hold();
        hold_sw = 1'b1; cyc(1); hold_sw = 1'b0; cyc(1);
    endtask
    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        cyc(4);
        rst_n = 1'b1;
        cmp_en = 1;
        cyc(2);
        cmp("R1 reset disp", 32'(disp), 32'h0);
        cmp("R3 reset mode", 32'(mode), 32'd0);
        cmp("R8 reset running", 32'(running), 32'd1);

        ticks(75);
        cmp("R1 packing 00:01:15", 32'(disp), 32'h000115);

        flip_hold();
        ticks(10);
        cmp("R8 held count", 32'(disp), 32'h000115);
        flip_hold();
        ticks(5);
        cmp("R8 resumed count", 32'(disp), 32'h000120);

        mode_sw = 3'b000; cyc(2);
        cmp("R3 invalid code keeps run", 32'(mode), 32'd0);
        ticks(1);
        cmp("R3 still counting", 32'(disp), 32'h000121);

        mode_sw = 3'b101; cyc(2);
        cmp("R6 set register shown", 32'(disp), 32'h000000);
        press_hr(1, 6);
        cmp("R12 long press one step", 32'(disp), 32'h010000);
        press_hr(22, 1);
        press_mn(59, 2);
        cmp("R4 R5 set 23:59", 32'(disp), 32'h235900);
        press_mn(1, 1);
        cmp("R5 minute wrap no carry", 32'(disp), 32'h230000);
        press_hr(1, 1);
        cmp("R4 hour wrap", 32'(disp), 32'h000000);
        press_hr(23, 1);
        press_mn(59, 1);

        mode_sw = 3'b110; cyc(1);
        cmp("R6 time loaded", 32'(disp), 32'h235900);
        ticks(59);
        cmp("R2 at 23:59:59", 32'(disp), 32'h235959);
        ticks(1);
        cmp("R2 day wrap", 32'(disp), 32'h000000);
        cmp("R10 chime at 00:00", 32'(chime), 32'd1);
        ticks(5);
        cmp("R10 chime at 00:05", 32'(chime), 32'd1);
        ticks(1);
        cmp("R10 chime off at 00:06", 32'(chime), 32'd0);

        mode_sw = 3'b011; cyc(1);
        cmp("R7 alarm shown", 32'(disp), 32'h000000);
        press_mn(1, 1);
        cmp("R7 alarm edit", 32'(disp), 32'h000100);
        ticks(3);
        mode_sw = 3'b110; cyc(1);
        cmp("R7 time frozen", 32'(disp), 32'h000006);
        cmp("R11 no match yet", 32'(alarm_hit), 32'd0);
        ticks(54);
        cmp("R11 match at 00:01", 32'(alarm_hit), 32'd1);
        ticks(60);
        cmp("R11 match ends", 32'(alarm_hit), 32'd0);

        press_hr(2, 1);
        press_mn(3, 1);
        mode_sw = 3'b011; cyc(1);
        cmp("R12 run keys ignored alarm", 32'(disp), 32'h000100);
        mode_sw = 3'b101; cyc(1);
        cmp("R12 run keys ignored set", 32'(disp), 32'h235900);
        mode_sw = 3'b110; cyc(2);

        ticks(7);
        tick = 1'b1; clear_n = 1'b0; cyc(1);
        cmp("R9 clear beats tick", 32'(disp), 32'h000000);
        clear_n = 1'b1; tick = 1'b0; cyc(1);

        for (int i = 0; i < 4000; i++) begin
            tick = ($urandom_range(0, 2) != 0);
            if ($urandom_range(0, 3) == 0) hr_key = ~hr_key;
            if ($urandom_range(0, 3) == 0) min_key = ~min_key;
            if ($urandom_range(0, 59) == 0) hold_sw = ~hold_sw;
            clear_n = ($urandom_range(0, 199) != 0);
            if ($urandom_range(0, 39) == 0) mode_sw = 3'($urandom_range(0, 7));
            cyc(1);
        end
        cyc(2);
        summary();
    end
endmodule